// File: doc/BRIEF.md
# Clock Reference Selector

This block decides where the local timing generator of a network clock unit takes its timing from. It can lock to a primary external reference, lock to a secondary reference that backs up the primary, or run free on its own oscillator. Each reference is qualified from three flags that arrive from the trunk interfaces and from configuration: whether a trunk loop is assigned to that role, whether the reference is enabled, and whether it is in local alarm. A reference counts as usable only when it is assigned, enabled and not in alarm.

When the unit is enabled it first spends a programmable number of timebase ticks in free run, then hands control to automatic selection. The automatic selector prefers the primary, falls back to the secondary when the primary fails, and falls back to free run when neither is usable. A return from the secondary to the primary happens only after the primary has stayed usable for a programmable number of consecutive ticks. An operator can override the automatic selector with a command that forces tracking of the primary, tracking of the secondary, or free run, and a further command hands control back. Every change of selected reference raises a one-cycle event and advances a wrapping event counter.

The timebase tick is an input strobe, so the warm-up and hold-off periods can be minutes long in a system and a handful of cycles in simulation.

Top module: `refsel_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mode_o is 00, sel_ref_o is 00, switch_pulse_o is 0 and switch_count_o is 0.
- R2: A reference is usable exactly when its assigned flag is 1, its enabled flag is 1 and its alarm flag is 0; sel_ref_o encodes free run as 00, primary as 01 and secondary as 10, never shows 11, and a reference is selected only if it was usable on the cycle before.
- R3: mode_o encodes warm-up as 00, automatic as 01 and manual as 10; after unit_en goes high the block stays in warm-up with sel_ref_o at 00 for WARMUP_TICKS ticks, and on the clock edge after the cycle in which the last tick was taken it enters automatic mode and makes its first selection.
- R4: When unit_en is 0 the next state is warm-up with free run, and the warm-up count restarts from zero.
- R5: In automatic mode from free run, the primary is chosen if usable, otherwise the secondary if usable, one clock edge after the inputs change.
- R6: In automatic mode while tracking the primary, loss of the primary selects the secondary if it is usable and free run otherwise (including when the secondary is unassigned), on the next clock edge.
- R7: In automatic mode while tracking the secondary, the block returns to the primary one edge after the primary has been usable for HOLDOFF_TICKS consecutive ticks; any cycle with the primary unusable restarts that count.
- R8: In automatic mode while tracking the secondary, loss of the secondary selects the primary at once if it is usable, without waiting for the hold-off, and free run otherwise.
- R9: A command with cmd_valid 1 and cmd_code 01, 10 or 11 puts the block in manual mode on the next edge, from any mode including warm-up; the target is primary, secondary or free run respectively, and the selection is the target when it is usable and free run when it is not.
- R10: A command with cmd_code 00 returns manual mode to automatic mode and applies the automatic rules from the current selection; in warm-up or automatic mode it has no effect.
- R11: switch_pulse_o is 1 for exactly the cycle after each change of sel_ref_o, and switch_count_o then rises by one, wrapping modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_en | input | 1 | Unit enabled; low forces warm-up |
| tick | input | 1 | Timebase strobe for the warm-up and hold-off counts |
| pri_assigned | input | 1 | A loop is assigned as primary reference |
| pri_enabled | input | 1 | Primary reference enabled |
| pri_alarm | input | 1 | Primary reference in local alarm |
| sec_assigned | input | 1 | A loop is assigned as secondary reference |
| sec_enabled | input | 1 | Secondary reference enabled |
| sec_alarm | input | 1 | Secondary reference in local alarm |
| cmd_valid | input | 1 | Operator command strobe |
| cmd_code | input | 2 | 00 automatic, 01 primary, 10 secondary, 11 free run |
| mode_o | output | 2 | 00 warm-up, 01 automatic, 10 manual |
| sel_ref_o | output | 2 | 00 free run, 01 primary, 10 secondary |
| switch_pulse_o | output | 1 | One-cycle event on each selection change |
| switch_count_o | output | CNT_W | Wrapping count of selection changes |

## Verification
The assertions watch, on every cycle, that the selection code is legal, that free run holds throughout warm-up and after the unit is disabled, that a tracked reference was usable the cycle before, that automatic mode with no usable reference lands in free run, that a forced free-run command takes effect, and that the event pulse and counter step exactly with selection changes. The timed behaviours need the bench's scenarios: the warm-up boundary at the last tick, the revertive hold-off including a restart by a brief primary alarm, the immediate fall to the primary when the secondary fails, sweeps over all flag combinations of each reference under manual control, and counter wrap-around after several hundred switches.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  localparam int NUM_REF = 2;
  localparam int IDX_PRI = 0;
  localparam int IDX_SEC = 1;

  typedef enum logic [1:0] {
    SEL_FREE = 2'b00,
    SEL_PRI  = 2'b01,
    SEL_SEC  = 2'b10
  } sel_e;

  typedef enum logic [1:0] {
    MODE_WARM = 2'b00,
    MODE_AUTO = 2'b01,
    MODE_MAN  = 2'b10
  } mode_e;

  localparam logic [1:0] CMD_AUTO = 2'b00;
  localparam logic [1:0] CMD_PRI  = 2'b01;
  localparam logic [1:0] CMD_SEC  = 2'b10;
  localparam logic [1:0] CMD_FREE = 2'b11;

  // Automatic rule set, evaluated from the current selection.
  function automatic sel_e auto_pick(input sel_e cur, input logic up,
                                     input logic us, input logic hold_ok);
    sel_e r;
    case (cur)
      SEL_PRI: r = up ? SEL_PRI : (us ? SEL_SEC : SEL_FREE);
      SEL_SEC: begin
        if (us) r = (up && hold_ok) ? SEL_PRI : SEL_SEC;
        else    r = up ? SEL_PRI : SEL_FREE;
      end
      default: r = up ? SEL_PRI : (us ? SEL_SEC : SEL_FREE);
    endcase
    return r;
  endfunction

  // Manual target, honoured only while the target is usable.
  function automatic sel_e man_pick(input sel_e tgt, input logic up,
                                    input logic us);
    sel_e r;
    case (tgt)
      SEL_PRI: r = up ? SEL_PRI : SEL_FREE;
      SEL_SEC: r = us ? SEL_SEC : SEL_FREE;
      default: r = SEL_FREE;
    endcase
    return r;
  endfunction

  function automatic sel_e code_to_target(input logic [1:0] code);
    sel_e r;
    case (code)
      CMD_PRI: r = SEL_PRI;
      CMD_SEC: r = SEL_SEC;
      default: r = SEL_FREE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/refsel_qual.sv
module refsel_qual #(
  parameter int NREF = 2
) (
  input  logic [NREF-1:0] assigned_i,
  input  logic [NREF-1:0] enabled_i,
  input  logic [NREF-1:0] alarm_i,
  output logic [NREF-1:0] usable_o
);

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    assign usable_o[g] = assigned_i[g] & enabled_i[g] & ~alarm_i[g];
  end

endmodule

// File: rtl/refsel_timer.sv
module refsel_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic done
);

  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM);

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                unit_en,
  input  logic [NUM_REF-1:0]  usable,
  input  logic                warm_done,
  input  logic                hold_done,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_code,
  output mode_e               mode_q,
  output sel_e                sel_q,
  output sel_e                sel_n
);

  mode_e mode_n;
  sel_e  tgt_q, tgt_n;
  logic  up, us, force_cmd, auto_cmd;

  assign up        = usable[IDX_PRI];
  assign us        = usable[IDX_SEC];
  assign force_cmd = cmd_valid && (cmd_code != CMD_AUTO);
  assign auto_cmd  = cmd_valid && (cmd_code == CMD_AUTO);

  always_comb begin
    mode_n = mode_q;
    sel_n  = sel_q;
    tgt_n  = tgt_q;
    if (!unit_en) begin
      mode_n = MODE_WARM;
      sel_n  = SEL_FREE;
    end else if (force_cmd) begin
      mode_n = MODE_MAN;
      tgt_n  = code_to_target(cmd_code);
      sel_n  = man_pick(tgt_n, up, us);
    end else begin
      case (mode_q)
        MODE_WARM: begin
          if (warm_done) begin
            mode_n = MODE_AUTO;
            sel_n  = auto_pick(SEL_FREE, up, us, hold_done);
          end else begin
            sel_n = SEL_FREE;
          end
        end
        MODE_AUTO: sel_n = auto_pick(sel_q, up, us, hold_done);
        MODE_MAN: begin
          if (auto_cmd) begin
            mode_n = MODE_AUTO;
            sel_n  = auto_pick(sel_q, up, us, hold_done);
          end else begin
            sel_n = man_pick(tgt_q, up, us);
          end
        end
        default: begin
          mode_n = MODE_WARM;
          sel_n  = SEL_FREE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_WARM;
      sel_q  <= SEL_FREE;
      tgt_q  <= SEL_FREE;
    end else begin
      mode_q <= mode_n;
      sel_q  <= sel_n;
      tgt_q  <= tgt_n;
    end
  end

endmodule

// File: rtl/refsel_evt.sv
module refsel_evt
  import refsel_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sel_e             sel_cur,
  input  sel_e             sel_nxt,
  output logic             pulse_q,
  output logic [CNT_W-1:0] count_q
);

  logic change;
  assign change = (sel_cur != sel_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      count_q <= '0;
    end else begin
      pulse_q <= change;
      if (change) count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int WARMUP_TICKS  = 8,
  parameter int HOLDOFF_TICKS = 4,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             unit_en,
  input  logic             tick,
  input  logic             pri_assigned,
  input  logic             pri_enabled,
  input  logic             pri_alarm,
  input  logic             sec_assigned,
  input  logic             sec_enabled,
  input  logic             sec_alarm,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  output logic [1:0]       mode_o,
  output logic [1:0]       sel_ref_o,
  output logic             switch_pulse_o,
  output logic [CNT_W-1:0] switch_count_o
);

  logic [NUM_REF-1:0] usable;
  logic               warm_done, hold_done;
  logic               warm_clr, hold_clr;
  mode_e              mode_q;
  sel_e               sel_q, sel_n;

  refsel_qual #(.NREF(NUM_REF)) u_qual (
    .assigned_i ({sec_assigned, pri_assigned}),
    .enabled_i  ({sec_enabled,  pri_enabled}),
    .alarm_i    ({sec_alarm,    pri_alarm}),
    .usable_o   (usable)
  );

  assign warm_clr = !unit_en || (mode_q != MODE_WARM);
  assign hold_clr = !usable[IDX_PRI];

  refsel_timer #(.LIMIT(WARMUP_TICKS)) u_warm (
    .clk  (clk),
    .rst  (rst),
    .clr  (warm_clr),
    .tick (tick),
    .done (warm_done)
  );

  refsel_timer #(.LIMIT(HOLDOFF_TICKS)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .clr  (hold_clr),
    .tick (tick),
    .done (hold_done)
  );

  refsel_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .unit_en   (unit_en),
    .usable    (usable),
    .warm_done (warm_done),
    .hold_done (hold_done),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .mode_q    (mode_q),
    .sel_q     (sel_q),
    .sel_n     (sel_n)
  );

  refsel_evt #(.CNT_W(CNT_W)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .sel_cur (sel_q),
    .sel_nxt (sel_n),
    .pulse_q (switch_pulse_o),
    .count_q (switch_count_o)
  );

  assign mode_o    = mode_q;
  assign sel_ref_o = sel_q;

endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             unit_en,
  input logic             pri_assigned,
  input logic             pri_enabled,
  input logic             pri_alarm,
  input logic             sec_assigned,
  input logic             sec_enabled,
  input logic             sec_alarm,
  input logic             cmd_valid,
  input logic [1:0]       cmd_code,
  input logic [1:0]       mode_o,
  input logic [1:0]       sel_ref_o,
  input logic             switch_pulse_o,
  input logic [CNT_W-1:0] switch_count_o
);

  logic up_in, us_in;
  assign up_in = pri_assigned && pri_enabled && !pri_alarm;
  assign us_in = sec_assigned && sec_enabled && !sec_alarm;

  p_sel_legal_r2: assert property (@(posedge clk) disable iff (rst)
    sel_ref_o != 2'b11);

  p_pri_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_ref_o == 2'b01) |-> $past(up_in));

  p_sec_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_ref_o == 2'b10) |-> $past(us_in));

  p_none_free_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01 && !cmd_valid && !up_in && !us_in) |=> sel_ref_o == 2'b00);

  p_warm_free_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00) |-> sel_ref_o == 2'b00);

  p_disable_r4: assert property (@(posedge clk) disable iff (rst)
    !unit_en |=> (mode_o == 2'b00 && sel_ref_o == 2'b00));

  p_force_free_r9: assert property (@(posedge clk) disable iff (rst)
    (unit_en && cmd_valid && cmd_code == 2'b11) |=> (mode_o == 2'b10 && sel_ref_o == 2'b00));

  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    switch_pulse_o == (sel_ref_o != $past(sel_ref_o)));

  p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
    switch_pulse_o |-> switch_count_o == CNT_W'($past(switch_count_o) + 1'b1));

  p_count_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !switch_pulse_o |-> $stable(switch_count_o));

endmodule

bind refsel_ctrl refsel_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .unit_en        (unit_en),
  .pri_assigned   (pri_assigned),
  .pri_enabled    (pri_enabled),
  .pri_alarm      (pri_alarm),
  .sec_assigned   (sec_assigned),
  .sec_enabled    (sec_enabled),
  .sec_alarm      (sec_alarm),
  .cmd_valid      (cmd_valid),
  .cmd_code       (cmd_code),
  .mode_o         (mode_o),
  .sel_ref_o      (sel_ref_o),
  .switch_pulse_o (switch_pulse_o),
  .switch_count_o (switch_count_o)
);

// File: tb/refsel_ctrl_tb.sv
`timescale 1ns/1ps
module refsel_ctrl_tb;

  localparam int WARM = 8;
  localparam int HOLD = 4;
  localparam int CW   = 8;

  localparam logic [1:0] M_WARM = 2'b00, M_AUTO = 2'b01, M_MAN = 2'b10;
  localparam logic [1:0] S_FREE = 2'b00, S_PRI = 2'b01, S_SEC = 2'b10;

  logic clk = 1'b0;
  logic rst, unit_en, tick;
  logic pa, pe, pl, sa, se, sl;
  logic cmd_valid;
  logic [1:0] cmd_code;
  logic [1:0] mode_o, sel_ref_o;
  logic switch_pulse_o;
  logic [CW-1:0] switch_count_o;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  logic [1:0]    last_sel;
  logic [CW-1:0] exp_cnt;

  always #5 clk = ~clk;

  refsel_ctrl #(.WARMUP_TICKS(WARM), .HOLDOFF_TICKS(HOLD), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .unit_en(unit_en), .tick(tick),
    .pri_assigned(pa), .pri_enabled(pe), .pri_alarm(pl),
    .sec_assigned(sa), .sec_enabled(se), .sec_alarm(sl),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .mode_o(mode_o), .sel_ref_o(sel_ref_o),
    .switch_pulse_o(switch_pulse_o), .switch_count_o(switch_count_o)
  );

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Compares all outputs; pulse and count follow from the selection history.
  task automatic expect_st(input string tag, input logic [1:0] m, input logic [1:0] s);
    logic ep;
    ep = (s != last_sel);
    if (ep) exp_cnt = exp_cnt + 1'b1;
    last_sel = s;
    checks++;
    if (mode_o !== m || sel_ref_o !== s || switch_pulse_o !== ep || switch_count_o !== exp_cnt) begin
      bad++;
      $display("FAIL %s: got mode=%b sel=%b pulse=%b cnt=%0d, expected mode=%b sel=%b pulse=%b cnt=%0d",
               tag, mode_o, sel_ref_o, switch_pulse_o, switch_count_o, m, s, ep, exp_cnt);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1;
    cycle();
    tick = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    cycle();
    cmd_valid = 1'b0;
    cmd_code  = 2'b00;
  endtask

  function automatic logic [1:0] pri_only(input logic a, input logic e, input logic l);
    return (a && e && !l) ? S_PRI : S_FREE;
  endfunction

  initial begin
    rst = 1'b1; unit_en = 1'b0; tick = 1'b0;
    pa = 0; pe = 0; pl = 0; sa = 0; se = 0; sl = 0;
    cmd_valid = 1'b0; cmd_code = 2'b00;
    last_sel = S_FREE; exp_cnt = '0;
    @(negedge clk);
    cycle(); cycle(); cycle();
    expect_st("R1 in reset", M_WARM, S_FREE);
    rst = 1'b0; unit_en = 1'b1;
    pa = 1; pe = 1; sa = 1; se = 1;
    cycle();
    expect_st("R1 after reset", M_WARM, S_FREE);

    // Warm-up: free run until the last tick, then automatic
    for (int i = 1; i < WARM; i++) begin
      do_tick();
      expect_st("R3 warm-up tick", M_WARM, S_FREE);
    end
    do_cmd(2'b00);
    expect_st("R10 auto command ignored in warm-up", M_WARM, S_FREE);
    do_tick();
    expect_st("R3 last tick edge", M_WARM, S_FREE);
    cycle();
    expect_st("R3 R5 enter automatic on primary", M_AUTO, S_PRI);
    cycle();
    expect_st("R11 pulse clears", M_AUTO, S_PRI);

    // Manual primary with all primary flag combinations
    do_cmd(2'b01);
    expect_st("R9 force primary", M_MAN, S_PRI);
    for (int i = 0; i < 8; i++) begin
      {pa, pe, pl} = 3'(i);
      cycle();
      expect_st("R2 R9 primary qualification", M_MAN, pri_only(pa, pe, pl));
    end
    pa = 1; pe = 1; pl = 0;
    cycle();
    expect_st("R9 primary restored", M_MAN, S_PRI);

    // Manual secondary with all secondary flag combinations
    do_cmd(2'b10);
    expect_st("R9 force secondary", M_MAN, S_SEC);
    for (int i = 0; i < 8; i++) begin
      {sa, se, sl} = 3'(i);
      cycle();
      expect_st("R2 R9 secondary qualification", M_MAN,
                (sa && se && !sl) ? S_SEC : S_FREE);
    end
    sa = 1; se = 1; sl = 0;
    cycle();
    expect_st("R9 secondary restored", M_MAN, S_SEC);

    do_cmd(2'b11);
    expect_st("R9 force free run", M_MAN, S_FREE);
    cycle();
    expect_st("R9 free run held with both usable", M_MAN, S_FREE);
    do_cmd(2'b00);
    expect_st("R10 R5 back to automatic picks primary", M_AUTO, S_PRI);
    do_cmd(2'b00);
    expect_st("R10 auto command in automatic no effect", M_AUTO, S_PRI);

    // Primary loss and revertive hold-off
    pl = 1;
    cycle();
    expect_st("R6 primary lost to secondary", M_AUTO, S_SEC);
    pl = 0;
    cycle();
    expect_st("R7 no immediate revert", M_AUTO, S_SEC);
    for (int i = 0; i < HOLD - 1; i++) begin
      do_tick();
      expect_st("R7 hold-off counting", M_AUTO, S_SEC);
    end
    pl = 1;
    cycle();
    expect_st("R7 glitch keeps secondary", M_AUTO, S_SEC);
    pl = 0;
    cycle();
    expect_st("R7 glitch cleared", M_AUTO, S_SEC);
    for (int i = 0; i < HOLD - 1; i++) begin
      do_tick();
      expect_st("R7 hold-off restarted", M_AUTO, S_SEC);
    end
    do_tick();
    expect_st("R7 last hold-off tick edge", M_AUTO, S_SEC);
    cycle();
    expect_st("R7 revert to primary", M_AUTO, S_PRI);

    // Both unusable
    se = 0; pl = 1;
    cycle();
    expect_st("R6 primary lost, secondary disabled", M_AUTO, S_FREE);
    se = 1;
    cycle();
    expect_st("R5 free run to secondary", M_AUTO, S_SEC);
    pl = 0; sl = 1;
    cycle();
    expect_st("R8 secondary lost to primary without hold-off", M_AUTO, S_PRI);
    pl = 1;
    cycle();
    expect_st("R6 primary lost, secondary in alarm", M_AUTO, S_FREE);
    pl = 0; sl = 0;
    cycle();
    expect_st("R5 primary preferred from free run", M_AUTO, S_PRI);
    sa = 0; pl = 1;
    cycle();
    expect_st("R6 unassigned secondary gives free run", M_AUTO, S_FREE);
    pl = 0;
    cycle();
    expect_st("R5 primary recovers", M_AUTO, S_PRI);
    sa = 1; pl = 1;
    cycle();
    expect_st("R6 primary lost to secondary", M_AUTO, S_SEC);
    sl = 1;
    cycle();
    expect_st("R8 secondary lost, primary bad", M_AUTO, S_FREE);
    sl = 0; pl = 0;
    cycle();
    expect_st("R5 both back", M_AUTO, S_PRI);

    // Disable restarts warm-up
    unit_en = 0;
    cycle();
    expect_st("R4 disable forces warm-up", M_WARM, S_FREE);
    unit_en = 1;
    cycle();
    expect_st("R4 re-enabled in warm-up", M_WARM, S_FREE);
    for (int i = 1; i < WARM; i++) begin
      do_tick();
      expect_st("R4 warm-up restarted", M_WARM, S_FREE);
    end
    do_tick();
    expect_st("R4 last tick edge", M_WARM, S_FREE);
    cycle();
    expect_st("R4 automatic again", M_AUTO, S_PRI);

    // Counter wrap
    sa = 0;
    for (int i = 0; i < 140; i++) begin
      pl = 1;
      cycle();
      expect_st("R11 toggle to free run", M_AUTO, S_FREE);
      pl = 0;
      cycle();
      expect_st("R11 toggle to primary", M_AUTO, S_PRI);
    end
    cycle();
    expect_st("R11 counter after wrap", M_AUTO, S_PRI);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", checks + 1, bad + 1);
      $finish;
    end
  end

endmodule